// File: doc/BRIEF.md
# Two-Channel Break Sequencer

This block turns the match pulses of two address/data comparator channels, A and B, into a single break request for the processor's debug logic. In independent mode either channel's match raises a break. In sequential mode channel A's match only arms the block; a break follows when channel B matches afterwards. Channel B matches seen while the block is not armed are dropped. A channel A and channel B match in the same cycle are dropped as well. An optional execution count can make the block wait for the n-th channel B match after arming.

With every break the block records the program-counter value the handler returns to. The value is the current instruction's address when the condition stops the instruction before it runs. It is the next instruction's address when the matching instruction completes first. The block also reports whether the value goes to the ordinary saved-PC register or to the fixed emulation save location. The request is a one-cycle pulse. No further request is issued until the consumer acknowledges the current one. Exception vectoring happens elsewhere.

Top module: `brk_seq_core`

## Requirements
- R1: With `seq_mode`=0 and no request pending, a cycle with `hit_a` or `hit_b` high gives a one-cycle `brk_req` pulse on the next cycle. When both are high, `kind_a` selects the saved PC.
- R2: With `seq_mode`=1, a `hit_b` while the block is not armed is ignored: no `brk_req` follows, and the block does not arm.
- R3: With `seq_mode`=1 and the block not armed, `hit_a` and `hit_b` high in the same cycle give no break. They also do not arm the block, so a later lone `hit_b` is still ignored.
- R4: With `seq_mode`=1 and `cnt_en`=0, the first `hit_b` after an arming `hit_a` gives `brk_req` on the next cycle.
- R5: With `seq_mode`=1 and `cnt_en`=1, arming loads `cnt_init`. Each armed `hit_b` counts down, and the break fires on the `hit_b` that brings the count to zero. A `cnt_init` of 0 or 1 fires on the first `hit_b`, and an armed `hit_a` does not reload the count.
- R6: Kind code 2'b00 (fetch, break before execution) saves `pc_cur` of the firing cycle into `save_pc`.
- R7: Kind codes 2'b01 (fetch, break after execution), 2'b10 (data access, address only) and 2'b11 (data access with value) save `pc_next` of the firing cycle.
- R8: If `emu_mode` is high in the firing cycle, `save_fixed`=1 and `save_loc`=0xFD000000. Otherwise both are 0, which selects the normal saved-PC register.
- R9: The armed state clears when a break fires and whenever `seq_mode` is 0. After either, a lone `hit_b` in sequential mode gives no break.
- R10: `brk_req` is high for one cycle only. From the firing cycle until a cycle with `brk_ack` high, every hit is ignored, including hits in the acknowledging cycle. Ignored hits neither arm the block nor count.
- R11: After reset `brk_req`=0, `save_pc`=0, `save_fixed`=0, `save_loc`=0, the block is unarmed and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_mode | input | 1 | 1 = sequential A-then-B mode |
| cnt_en | input | 1 | Enables the execution-count qualifier on channel B |
| cnt_init | input | CW | Number of channel B matches needed after arming |
| emu_mode | input | 1 | Break goes to the fixed emulation save location |
| hit_a | input | 1 | Channel A match pulse |
| hit_b | input | 1 | Channel B match pulse |
| kind_a | input | 2 | Condition kind of channel A |
| kind_b | input | 2 | Condition kind of channel B |
| pc_cur | input | AW | Address of the matching instruction |
| pc_next | input | AW | Address of the following instruction |
| brk_ack | input | 1 | Consumer has taken the pending request |
| brk_req | output | 1 | One-cycle break request |
| save_pc | output | AW | Program counter to save |
| save_fixed | output | 1 | 1 = save to the fixed location |
| save_loc | output | AW | Fixed save address when `save_fixed`, else 0 |

## Verification
The vector table runs independent mode with lone A hits, lone B hits and double hits, which separates the OR of the channels from the A-priority kind choice. Sequential mode gets B-before-A, same-cycle A and B, A then B, and mode drops between A and B. These show whether only a strictly earlier lone A arms the block and what clears the armed state. Count runs of 3, 1 and 0 with an A inserted mid-count show whether the counter fires on the right match and is not reloaded. Hits during a pending request and in the acknowledge cycle show that blocked hits leave no trace. Directed resets, one while armed and one while pending, show that both states clear.

// File: rtl/brk_seq_core.sv
module brk_seq_core #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter logic [AW-1:0] FIX_LOC = AW'('hFD00_0000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seq_mode,
  input  logic          cnt_en,
  input  logic [CW-1:0] cnt_init,
  input  logic          emu_mode,
  input  logic          hit_a,
  input  logic          hit_b,
  input  logic [1:0]    kind_a,
  input  logic [1:0]    kind_b,
  input  logic [AW-1:0] pc_cur,
  input  logic [AW-1:0] pc_next,
  input  logic          brk_ack,
  output logic          brk_req,
  output logic [AW-1:0] save_pc,
  output logic          save_fixed,
  output logic [AW-1:0] save_loc
);

  localparam logic [1:0] KIND_PRE = 2'b00;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          armed, pend;
  logic [CW-1:0] cnt_q;

  wire cnt_last = !cnt_en || (cnt_q <= CNT_ONE);
  wire ind_fire = !seq_mode && (hit_a || hit_b);
  wire seq_fire = seq_mode && armed && hit_b && cnt_last;
  wire fire     = !pend && (ind_fire || seq_fire);
  wire arm_set  = seq_mode && !pend && !armed && hit_a && !hit_b;
  wire cnt_step = seq_mode && !pend && armed && hit_b && !cnt_last;

  wire [1:0]    fire_kind = (!seq_mode && hit_a) ? kind_a : kind_b;
  wire [AW-1:0] pick_pc   = (fire_kind == KIND_PRE) ? pc_cur : pc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (!seq_mode || fire) armed <= 1'b0;
      else if (arm_set)      armed <= 1'b1;
      if (arm_set)       cnt_q <= cnt_init;
      else if (cnt_step) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      brk_req    <= 1'b0;
      save_pc    <= '0;
      save_fixed <= 1'b0;
    end else begin
      brk_req <= fire;
      if (fire) begin
        pend       <= 1'b1;
        save_pc    <= pick_pc;
        save_fixed <= emu_mode;
      end else if (brk_ack) begin
        pend <= 1'b0;
      end
    end
  end

  assign save_loc = save_fixed ? FIX_LOC : '0;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req); // R10
  AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !brk_req); // R10
  AST_B_FIRST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !armed && hit_b) |=> !brk_req); // R2
  AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_mode |=> !armed); // R9
  AST_FETCH_PRE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && !pend && hit_a && kind_a == KIND_PRE) |=>
      (brk_req && save_pc == $past(pc_cur))); // R6
  AST_NEXT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && !pend && hit_a && kind_a != KIND_PRE) |=>
      (brk_req && save_pc == $past(pc_next))); // R7
  AST_FIXED_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && ind_fire) |=> (save_fixed == $past(emu_mode))); // R8

endmodule

// File: tb/brk_seq_core_tb_top.sv
module brk_seq_core_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 34;
  localparam logic [AW-1:0] FIX = 32'hFD00_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seq_mode = 0, cnt_en = 0, emu_mode = 0, hit_a = 0, hit_b = 0, brk_ack = 0;
  logic [CW-1:0] cnt_init = '0;
  logic [1:0] kind_a = 0, kind_b = 0;
  logic [AW-1:0] pc_cur = '0, pc_next = '0;
  logic brk_req, save_fixed;
  logic [AW-1:0] save_pc, save_loc;

  int errors = 0, checks = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_seq_core #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode), .cnt_en(cnt_en),
    .cnt_init(cnt_init), .emu_mode(emu_mode), .hit_a(hit_a), .hit_b(hit_b),
    .kind_a(kind_a), .kind_b(kind_b), .pc_cur(pc_cur), .pc_next(pc_next),
    .brk_ack(brk_ack), .brk_req(brk_req), .save_pc(save_pc),
    .save_fixed(save_fixed), .save_loc(save_loc));

  // {seq, cen, cinit[3:0], emu, ha, hb, ka[1:0], kb[1:0], ack, exp_req, exp_next, exp_fix}
  function automatic logic [16:0] mk(bit s, bit ce, int ci, bit em, bit ha, bit hb,
                                     int ka, int kb, bit ak, bit er, bit en, bit ef);
    return {s, ce, 4'(ci), em, ha, hb, 2'(ka), 2'(kb), ak, er, en, ef};
  endfunction

  localparam logic [16:0] VEC [NV] = '{
    mk(0,0,0,0,1,0,0,0,0,1,0,0), // 0  R1 R6 A alone fires, pc_cur
    mk(0,0,0,0,0,1,0,0,1,0,0,0), // 1  R10 hit in ack cycle ignored
    mk(0,0,0,0,0,1,0,1,0,1,1,0), // 2  R1 R7 B alone, kind 01
    mk(0,0,0,0,1,0,0,0,0,0,0,0), // 3  R10 pending blocks
    mk(0,0,0,0,0,0,0,0,1,0,0,0), // 4  ack
    mk(0,0,0,1,1,1,2,0,0,1,1,1), // 5  R1 R8 both: kind A (10) wins, fixed
    mk(0,0,0,0,0,0,0,0,1,0,0,0), // 6  ack
    mk(1,0,0,0,0,1,0,0,0,0,0,0), // 7  R2 B first ignored
    mk(1,0,0,0,1,1,0,0,0,0,0,0), // 8  R3 simultaneous
    mk(1,0,0,0,0,1,0,0,0,0,0,0), // 9  R3 not armed
    mk(1,0,0,0,1,0,0,0,0,0,0,0), // 10 arm
    mk(1,0,0,0,0,1,0,0,0,1,0,0), // 11 R4 B after A, pc_cur
    mk(1,0,0,0,0,0,0,0,1,0,0,0), // 12 ack
    mk(1,0,0,0,0,1,0,0,0,0,0,0), // 13 R9 cleared by fire
    mk(1,0,0,0,1,0,0,0,0,0,0,0), // 14 arm
    mk(0,0,0,0,0,0,0,0,0,0,0,0), // 15 mode off
    mk(1,0,0,0,0,1,0,0,0,0,0,0), // 16 R9 cleared by mode off
    mk(1,1,3,0,1,0,0,0,0,0,0,0), // 17 R5 arm count 3
    mk(1,1,3,0,0,1,0,0,0,0,0,0), // 18 R5 3->2
    mk(1,1,3,0,1,0,0,0,0,0,0,0), // 19 R5 A no reload
    mk(1,1,3,0,0,1,0,0,0,0,0,0), // 20 R5 2->1
    mk(1,1,3,0,0,1,0,2,0,1,1,0), // 21 R5 R7 fires, kind 10
    mk(1,1,3,0,0,0,0,0,1,0,0,0), // 22 ack
    mk(1,1,1,0,1,0,0,0,0,0,0,0), // 23 arm count 1
    mk(1,1,1,1,0,1,0,3,0,1,1,1), // 24 R5 R7 R8 first B, kind 11
    mk(1,1,1,0,0,0,0,0,1,0,0,0), // 25 ack
    mk(1,1,0,0,1,0,0,0,0,0,0,0), // 26 arm count 0
    mk(1,1,0,0,0,1,0,0,0,1,0,0), // 27 R5 R6 count 0 acts as 1
    mk(1,1,0,0,0,0,0,0,1,0,0,0), // 28 ack
    mk(1,0,0,0,1,0,0,0,0,0,0,0), // 29 arm
    mk(1,0,0,0,0,1,0,1,0,1,1,0), // 30 R4 fire
    mk(1,0,0,0,1,0,0,0,0,0,0,0), // 31 R10 blocked A does not arm
    mk(1,0,0,0,0,1,0,0,1,0,0,0), // 32 R10 ack cycle B ignored
    mk(1,0,0,0,0,1,0,0,0,0,0,0)  // 33 R10 still unarmed
  };

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {seq_mode, cnt_en, emu_mode, hit_a, hit_b, brk_ack} = '0;
    cnt_init = '0; kind_a = 0; kind_b = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 req", 32'(brk_req), 0);
    chk("R11 pc", save_pc, 0);
    chk("R11 fixed", 32'(save_fixed), 0);
    chk("R11 loc", save_loc, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      logic [AW-1:0] pcc, pcn;
      v = VEC[i];
      pcc = 32'h0000_1000 + 32'(i) * 16;
      pcn = pcc + 2;
      {seq_mode, cnt_en} = v[16:15];
      cnt_init = CW'(v[14:11]);
      {emu_mode, hit_a, hit_b} = v[10:8];
      kind_a = v[7:6]; kind_b = v[5:4]; brk_ack = v[3];
      pc_cur = pcc; pc_next = pcn;
      @(negedge clk);
      chk($sformatf("R1/R2/R3/R4/R5/R9/R10 req step %0d", i), 32'(brk_req), 32'(v[2]));
      if (v[2]) begin
        chk($sformatf("R6/R7 pc step %0d", i), save_pc, v[1] ? pcn : pcc);
        chk($sformatf("R8 fixed step %0d", i), 32'(save_fixed), 32'(v[0]));
        chk($sformatf("R8 loc step %0d", i), save_loc, v[0] ? FIX : 32'h0);
      end
    end

    // R11: reset while armed clears the armed state
    idle(); seq_mode = 1; hit_a = 1; @(negedge clk);
    idle(); seq_mode = 1; rst_n = 0; @(negedge clk);
    chk("R11 req in reset", 32'(brk_req), 0);
    rst_n = 1; hit_b = 1; @(negedge clk);
    chk("R11 unarmed after reset", 32'(brk_req), 0);

    // R11: reset while pending clears the block; R1 fires right after
    idle(); hit_a = 1; emu_mode = 1; pc_cur = 32'h2000; pc_next = 32'h2002; @(negedge clk);
    chk("R1 fire before reset", 32'(brk_req), 1);
    chk("R8 loc fixed", save_loc, FIX);
    idle(); rst_n = 0; @(negedge clk);
    chk("R11 pc cleared", save_pc, 0);
    chk("R11 loc cleared", save_loc, 0);
    rst_n = 1; hit_b = 1; kind_b = 2'b10; pc_cur = 32'h3000; pc_next = 32'h3004; @(negedge clk);
    chk("R11 not pending after reset", 32'(brk_req), 1);
    chk("R7 data addr pc_next", save_pc, 32'h3004);
    idle(); @(negedge clk);
    chk("R10 single pulse", 32'(brk_req), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule